// File: doc/BRIEF.md
# Serial-Loaded Runt-Free Clock Freeze Controller

This block sits between a bank of clock sources and the output pins of a clock distribution device. A freeze mask arrives serially on a single data line. The line is clocked by a free-running serial clock. Each freezable output then either follows its source clock or is parked at logic 0. Stopping or restarting an output never produces a shortened high pulse.

A frame is one low start bit followed by one data bit per freezable output. The line idles high. The new mask takes effect only once the whole frame has been captured. Each mask bit is then carried into its own output clock domain and applied while that clock is low. Two outputs, the primary reference and the loop feedback, bypass the gating entirely. A garbled load can therefore never stop the loop that produces the clocks.

Top module: `frz_ctrl_top`

## Requirements
- R1: While reset is asserted, and after it is released until a frame completes, every output follows its source clock (all mask bits read as enabled).
- R2: A low level sampled on a rising serial clock edge while idle is a start bit. The next N_FRZ rising edges each capture one data bit. The first captured bit controls output 0, the next controls output 1, and so on up to output N_FRZ-1.
- R3: A mask bit of 1 makes its output follow its source clock. A mask bit of 0 holds its output at logic 0.
- R4: Output N_FRZ (primary reference) and output N_FRZ+1 (feedback) follow their sources whatever mask is loaded.
- R5: While the data line stays high in the idle state, no frame starts and the outputs keep their current mask.
- R6: The applied mask changes only at the edge that captures the last data bit of a frame. A frame still being shifted has no effect on the outputs.
- R7: After the last data bit the receiver hunts for a start bit again. Low data bits inside a frame do not start a frame. A start bit may directly follow the last data bit of the previous frame.
- R8: Every high pulse on every output lasts exactly as long as a high phase of its source. An output is never high while its source is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Free-running serial clock; data sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial frame input, idles high |
| clk_src | input | N_FRZ+2 | Source clocks, one per output |
| clk_out | output | N_FRZ+2 | Gated output clocks |

## Verification
A receiver that loses count of bits shifts the whole mask by one position or takes an in-frame zero as a new start bit. Either fault shows as the wrong set of outputs running within a few source cycles after the frame ends. Applying the mask too early appears on the outputs while the next frame is still being shifted. A gating cell that switches at the wrong phase shows as a high pulse shorter than the source's high phase, on the first freeze or release of that output.

// File: rtl/frz_pkg.sv
`timescale 1ns/1ps
package frz_pkg;
   typedef enum logic {
      RX_HUNT  = 1'b0,
      RX_SHIFT = 1'b1
   } frz_rx_state_e;
endpackage

// File: rtl/frz_serial_rx.sv
`timescale 1ns/1ps
module frz_serial_rx
   import frz_pkg::*;
#(
   parameter int N_FRZ = 12
) (
   input  logic             sclk,
   input  logic             rst_n,
   input  logic             sdata,
   output logic [N_FRZ-1:0] word_o,
   output logic             busy_o,
   output logic             last_o
);
   localparam int CW = $clog2(N_FRZ);
   localparam logic [CW-1:0] LAST = CW'(N_FRZ - 1);

   frz_rx_state_e    state;
   logic [CW-1:0]    cnt;
   logic [N_FRZ-1:0] shf;
   logic [N_FRZ-1:0] nxt;

   always_comb begin
      nxt      = shf;
      nxt[cnt] = sdata;
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= RX_HUNT;
         cnt    <= '0;
         shf    <= '0;
         word_o <= '1;
      end else begin
         case (state)
            RX_HUNT: begin
               cnt <= '0;
               if (!sdata) state <= RX_SHIFT;
            end
            RX_SHIFT: begin
               shf <= nxt;
               if (cnt == LAST) begin
                  word_o <= nxt;
                  state  <= RX_HUNT;
                  cnt    <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= RX_HUNT;
         endcase
      end
   end

   assign busy_o = (state == RX_SHIFT);
   assign last_o = busy_o && (cnt == LAST);
endmodule

// File: rtl/frz_sync.sv
`timescale 1ns/1ps
module frz_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '1;
      else        r <= {r[STAGES-2:0], d};
   end

   assign q = r[STAGES-1];
endmodule

// File: rtl/frz_gate.sv
`timescale 1ns/1ps
module frz_gate #(
   parameter int STYLE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic clk_o
);
   logic en_q;

   generate
      if (STYLE == 0) begin : g_negff
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= en;
         end
      end else begin : g_latch
         always_latch begin
            if (!rst_n)    en_q = 1'b1;
            else if (!clk) en_q = en;
         end
      end
   endgenerate

   assign clk_o = clk & en_q;
endmodule

// File: rtl/frz_ctrl_top.sv
`timescale 1ns/1ps
module frz_ctrl_top #(
   parameter int N_FRZ       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int GATE_STYLE  = 0,
   parameter int SHARED_SRC  = 0
) (
   input  logic             sclk,
   input  logic             rst_n,
   input  logic             sdata,
   input  logic [N_FRZ+1:0] clk_src,
   output logic [N_FRZ+1:0] clk_out
);
   localparam int N_OUT  = N_FRZ + 2;
   localparam int IDX_PRI = N_FRZ;
   localparam int IDX_FB  = N_FRZ + 1;

   generate
      if (N_FRZ < 2) begin : g_bad_nfrz
         $error("frz_ctrl_top: N_FRZ must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("frz_ctrl_top: SYNC_STAGES must be at least 2");
      end
      if (GATE_STYLE != 0 && GATE_STYLE != 1) begin : g_bad_gate
         $error("frz_ctrl_top: GATE_STYLE must be 0 or 1");
      end
   endgenerate

   logic [N_FRZ-1:0] act_word;
   logic             rx_busy;
   logic             rx_last;
   logic [N_OUT-1:0] src_sel;

   frz_serial_rx #(.N_FRZ(N_FRZ)) rx_i (
      .sclk   (sclk),
      .rst_n  (rst_n),
      .sdata  (sdata),
      .word_o (act_word),
      .busy_o (rx_busy),
      .last_o (rx_last)
   );

   generate
      if (SHARED_SRC != 0) begin : g_shared
         assign src_sel = {N_OUT{clk_src[0]}};
      end else begin : g_split
         assign src_sel = clk_src;
      end
   endgenerate

   generate
      for (genvar i = 0; i < N_FRZ; i++) begin : g_lane
         logic en_s;
         frz_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk   (src_sel[i]),
            .rst_n (rst_n),
            .d     (act_word[i]),
            .q     (en_s)
         );
         frz_gate #(.STYLE(GATE_STYLE)) gate_i (
            .clk   (src_sel[i]),
            .rst_n (rst_n),
            .en    (en_s),
            .clk_o (clk_out[i])
         );
      end
   endgenerate

   assign clk_out[IDX_PRI] = src_sel[IDX_PRI];
   assign clk_out[IDX_FB]  = src_sel[IDX_FB];
endmodule

// File: rtl/frz_ctrl_chk.sv
`timescale 1ns/1ps
module frz_ctrl_chk #(
   parameter int N_FRZ = 12
) (
   input logic             sclk,
   input logic             rst_n,
   input logic             sdata,
   input logic [N_FRZ+1:0] clk_src,
   input logic [N_FRZ+1:0] clk_out,
   input logic [N_FRZ-1:0] act_word,
   input logic             rx_busy,
   input logic             rx_last
);
   // R6
   mask_update_at_last_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (act_word != $past(act_word)) |-> $past(rx_last));

   // R5
   idle_high_stays_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (!rx_busy && sdata) |=> !rx_busy);

   // R2
   start_bit_detect_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (!rx_busy && !sdata) |=> rx_busy);

   // R7
   return_to_hunt_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      rx_last |=> !rx_busy);

   // R4
   primary_runs_chk: assert property (@(negedge clk_src[N_FRZ]) disable iff (!rst_n)
      clk_out[N_FRZ]);

   // R4
   feedback_runs_chk: assert property (@(negedge clk_src[N_FRZ+1]) disable iff (!rst_n)
      clk_out[N_FRZ+1]);

   generate
      for (genvar i = 0; i < N_FRZ + 2; i++) begin : g_low
         // R8
         low_while_src_low_chk: assert property (@(posedge clk_src[i]) disable iff (!rst_n)
            !clk_out[i]);
      end
   endgenerate
endmodule

bind frz_ctrl_top frz_ctrl_chk #(.N_FRZ(N_FRZ)) chk_i (
   .sclk     (sclk),
   .rst_n    (rst_n),
   .sdata    (sdata),
   .clk_src  (clk_src),
   .clk_out  (clk_out),
   .act_word (act_word),
   .rx_busy  (rx_busy),
   .rx_last  (rx_last)
);

// File: tb/frz_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module frz_ctrl_top_tb_top;
   localparam int NF = 12;
   localparam int NO = NF + 2;

   logic          sclk = 1'b0;
   logic          gclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sdata = 1'b1;
   logic [NO-1:0] clk_src;
   logic [NO-1:0] clk_out;

   int tests = 0;
   int fails = 0;
   int runt_errs = 0;
   bit finished = 0;
   bit mon_busy = 0;

   typedef struct {
      logic [NF-1:0] word;
      string         tag;
   } exp_t;
   exp_t exp_q[$];
   logic [NF-1:0] model_word = '1;

   always #2 sclk = ~sclk;   // 250 MHz serial clock
   always #3 gclk = ~gclk;   // source clock, 6 ns period
   assign clk_src = {NO{gclk}};

   frz_ctrl_top #(.N_FRZ(NF)) dut_i (
      .sclk    (sclk),
      .rst_n   (rst_n),
      .sdata   (sdata),
      .clk_src (clk_src),
      .clk_out (clk_out)
   );

   // R8: pulse width monitor on each output
   generate
      for (genvar i = 0; i < NO; i++) begin : g_pw
         realtime tr = -1.0;
         always @(posedge clk_out[i]) tr = rst_n ? $realtime : -1.0;
         always @(negedge clk_out[i]) begin
            if (rst_n && tr >= 0.0 && ($realtime - tr) != 3.0) runt_errs++;
            tr = -1.0;
         end
      end
   endgenerate

   task automatic check_vec(input logic [NO-1:0] act, input logic [NO-1:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: clk_out=%b expected %b", tag, act, exp);
      end
   endtask

   // sample: high phase should equal mask, low phase all zero
   task automatic sample_word(input logic [NF-1:0] w, input string tag, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(posedge gclk); #1;
         check_vec(clk_out, {2'b11, w}, tag);
         @(negedge gclk); #1;
         check_vec(clk_out, '0, tag);
      end
   endtask

   task automatic send_frame(input logic [NF-1:0] w, input bit push, input bit idle_after,
                             input string tag, input bit mid_check);
      logic [NF-1:0] prev = model_word;
      @(negedge sclk) sdata = 1'b0;
      for (int b = 0; b < NF; b++) begin
         @(negedge sclk) sdata = w[b];
         if (mid_check && b == 2) begin
            fork
               sample_word(prev, "R6 mask unchanged mid-frame", 3);
            join_none
         end
      end
      if (idle_after) @(negedge sclk) sdata = 1'b1;
      model_word = w;
      if (push) begin
         exp_q.push_back('{word: w, tag: tag});
         wait (exp_q.size() == 0 && !mon_busy);
      end
   endtask

   // scoreboard monitor
   initial begin
      exp_t it;
      forever begin
         wait (exp_q.size() > 0);
         mon_busy = 1;
         it = exp_q.pop_front();
         repeat (6) @(posedge gclk);
         sample_word(it.word, it.tag, 3);
         mon_busy = 0;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         tests++;
         if (runt_errs != 0) begin
            fails++;
            $display("FAIL R8: %0d pulses of wrong width, expected 0", runt_errs);
         end
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      tests++;
      fails++;
      $display("FAIL watchdog: run still active, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge sclk);
      // R1: outputs run during reset
      sample_word('1, "R1 run during reset", 2);
      @(negedge sclk) rst_n = 1'b1;
      exp_q.push_back('{word: '1, tag: "R1 run after reset"});
      wait (exp_q.size() == 0 && !mon_busy);

      // R3 R4: all freezable outputs frozen, two always-on still running
      send_frame(12'h000, 1, 1, "R3 R4 all frozen", 0);
      // R7 R5: idle high after a zero-filled frame must not start a frame
      repeat (40) @(negedge sclk);
      exp_q.push_back('{word: 12'h000, tag: "R5 R7 idle keeps mask"});
      wait (exp_q.size() == 0 && !mon_busy);

      // R2: bit ordering, first data bit drives output 0
      send_frame(12'h001, 1, 1, "R2 first bit to output 0", 0);
      send_frame(12'h800, 1, 1, "R2 last bit to output 11", 0);
      send_frame(12'hA5C, 1, 1, "R3 mixed mask", 0);

      // R6: old mask held while next frame shifts
      send_frame(12'h3F0, 1, 1, "R6 mask after full frame", 1);

      // R7: back-to-back frames with no idle gap
      send_frame(12'h0FE, 0, 0, "R7", 0);
      send_frame(12'h7C1, 1, 1, "R7 back-to-back frame", 0);

      // R1: reset mid-run restores all-running
      @(negedge sclk) rst_n = 1'b0;
      model_word = '1;
      repeat (4) @(negedge sclk);
      @(negedge sclk) rst_n = 1'b1;
      exp_q.push_back('{word: '1, tag: "R1 reset restores run"});
      wait (exp_q.size() == 0 && !mon_busy);

      send_frame(12'h555, 1, 1, "R3 alternating mask", 0);
      repeat (10) @(posedge gclk);
      finish_run();
   end
endmodule